// File: doc/BRIEF.md
# Camera Link Receiver Register Block

This block is the software-visible control and status front of a serial camera-link receiver. It connects to a simple 32-bit read/write bus that uses word-aligned offsets. It holds the programmed settings: global control, PHY control, stream configuration, image size and interrupt mask. It also gives the receiver datapath registered copies of those settings. Settings reach the datapath only when software requests a shadow update. This lets a whole new configuration be staged while a stream runs and then switched over in one cycle.

The receiver core reports events as one-cycle pulses. There are six error kinds, one start-of-transmission error per data lane, and four non-image-data events. Each pulse sets a sticky bit in the interrupt-source register. Software clears a bit by writing a one to its position. One interrupt line is raised while any unmasked source bit is set.

A self-clearing software-reset bit sends a one-cycle reset pulse to the datapath. The same pulse empties the sticky sources and the shadow copies but keeps the programmed registers.

Top module: `cam_rx_csr`

## Requirements
- R1: After the synchronous reset, every mapped register reads 0x00000000. `irq` is 0 and every datapath output is 0.
- R2: The registers sit at these byte offsets: control 0x00, PHY 0x04, configuration 0x08, mask 0x10, source 0x14, size 0x2C.
  - Each register keeps only its defined bits. Control keeps bits 31, 20, 8 and 0. PHY keeps 0xF800001F. Configuration keeps 0x000000FF. Mask keeps 0xF000103F. Size keeps all 32 bits.
  - `bus_rdata` shows the value one clock edge after `bus_rd` is sampled.
- R3: Datapath outputs keep their values while software writes new settings. They change only on the edge after a write that sets control bit 16. The mapping is:
  - `dp_dtype` from configuration bits 7:2 and `dp_lane_cnt` from configuration bits 1:0.
  - `dp_width` from size bits 31:16 and `dp_height` from size bits 15:0.
  - `dp_settle` from PHY bits 31:27.
  - `dp_align32` from control bit 20, `dp_wclk_ext` from control bit 8 and `dp_swap` from control bit 31.
- R4: Control bit 16 (update) self-clears one cycle after the write that set it. A later read of control shows it as 0.
- R5: At update, `dp_lane_en` becomes PHY bits 4:0 ANDed with a mask derived from the lane-count field N. The mask has bits 0 to N+1 set: the clock lane plus N+1 data lanes.
- R6: Writing control bit 4 drives `dp_soft_rst` high for exactly one cycle. On the next edge it clears all source bits and all shadow outputs. The programmed registers keep their values, and bit 4 reads back as 0.
- R7: The event inputs set sticky source bits, which stay set until cleared:
  - `ev_err[5:0]` sets bits 5:0 (unknown type, CRC, ECC, overflow, lost end, lost start).
  - `ev_sot[3:0]` sets bits 15:12.
  - `ev_nonimg[3:0]` sets bits 31:28.
- R8: A write to the source register clears exactly the bits written as one. Bits written as zero are unchanged.
- R9: When an event and a write-one clear hit the same bit in the same cycle, the bit stays set.
- R10: `irq` is high, one cycle after the state that causes it, whenever a source bit is set and its mask bit is set. Mask bit 12 covers all four start-of-transmission bits 15:12.
- R11: Reads of unmapped or misaligned addresses return zero. Writes to them change no register.
- R12: `dp_enable` follows control bit 0 directly, without waiting for a shadow update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ev_err | input | 6 | Error event pulses |
| ev_sot | input | 4 | Per-lane start-of-transmission error pulses |
| ev_nonimg | input | 4 | Non-image-data event pulses |
| irq | output | 1 | Interrupt request |
| dp_enable | output | 1 | Receiver enable |
| dp_soft_rst | output | 1 | One-cycle datapath reset |
| dp_swap | output | 1 | Differential-pair polarity swap (shadow) |
| dp_wclk_ext | output | 1 | External wrapper clock select (shadow) |
| dp_align32 | output | 1 | 32-bit data alignment (shadow) |
| dp_lane_cnt | output | 2 | Data lanes minus one (shadow) |
| dp_dtype | output | 6 | Data-type code (shadow) |
| dp_width | output | 16 | Image width (shadow) |
| dp_height | output | 16 | Image height (shadow) |
| dp_settle | output | 5 | High-speed settle count (shadow) |
| dp_lane_en | output | 5 | Effective lane enables (shadow) |

## Verification
The bench first rewrites the configuration without an update and confirms the datapath still sees the old values. A block that passed writes straight through would change `dp_dtype` early. It clears a source bit in the same cycle a new event hits that bit; a design that let the clear win would drop the event. It enables only mask bit 12 and raises a lane-2 start-of-transmission event. A design that did not spread that mask bit over bits 15:12 would never interrupt. A soft reset follows, and the bench checks that the programmed registers survive while the sources and shadows empty. A design that cleared everything, or nothing, would read back wrong values.

// File: rtl/cam_rx_pkg.sv
package cam_rx_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned LANE_EN_W = 5;
  localparam int unsigned SOT_W     = 4;
  localparam int unsigned ERR_W     = 6;
  localparam int unsigned NI_W      = 4;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_PHY  = 8'h04;
  localparam logic [7:0] OFF_CFG  = 8'h08;
  localparam logic [7:0] OFF_MASK = 8'h10;
  localparam logic [7:0] OFF_SRC  = 8'h14;
  localparam logic [7:0] OFF_RES  = 8'h2C;

  localparam logic [REG_W-1:0] CTRL_KEEP = 32'h8010_0101;
  localparam logic [REG_W-1:0] PHY_KEEP  = 32'hF800_001F;
  localparam logic [REG_W-1:0] CFG_KEEP  = 32'h0000_00FF;
  localparam logic [REG_W-1:0] MASK_KEEP = 32'hF000_103F;
  localparam logic [REG_W-1:0] SRC_KEEP  = 32'hF000_F03F;

  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_SRST  = 4;
  localparam int unsigned B_WCLK  = 8;
  localparam int unsigned B_UPD   = 16;
  localparam int unsigned B_ALIGN = 20;
  localparam int unsigned B_SWAP  = 31;
  localparam int unsigned B_SOT0  = 12;

  typedef struct packed {
    logic                 swap;
    logic                 align32;
    logic                 wclk_ext;
    logic [1:0]           lane_cnt;
    logic [5:0]           dtype;
    logic [15:0]          width;
    logic [15:0]          height;
    logic [4:0]           settle;
    logic [LANE_EN_W-1:0] lane_en;
  } shadow_t;
endpackage

// File: rtl/cam_rx_regbank.sv
module cam_rx_regbank
  import cam_rx_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic [REG_W-1:0] src_q,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] phy_q,
  output logic [REG_W-1:0] cfg_q,
  output logic [REG_W-1:0] res_q,
  output logic [REG_W-1:0] mask_q,
  output logic             upd_pulse,
  output logic             srst_pulse,
  output logic [REG_W-1:0] clr_vec,
  output logic [REG_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_PHY  = ADDR_W'(OFF_PHY);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(OFF_SRC);
  localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(OFF_RES);

  logic aligned;
  logic sel_ctrl, sel_phy, sel_cfg, sel_mask, sel_src, sel_res, sel_any;
  logic [REG_W-1:0] rd_mux;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign sel_ctrl = aligned && (bus_addr[ADDR_W-1:2] == A_CTRL[ADDR_W-1:2]);
  assign sel_phy  = aligned && (bus_addr[ADDR_W-1:2] == A_PHY[ADDR_W-1:2]);
  assign sel_cfg  = aligned && (bus_addr[ADDR_W-1:2] == A_CFG[ADDR_W-1:2]);
  assign sel_mask = aligned && (bus_addr[ADDR_W-1:2] == A_MASK[ADDR_W-1:2]);
  assign sel_src  = aligned && (bus_addr[ADDR_W-1:2] == A_SRC[ADDR_W-1:2]);
  assign sel_res  = aligned && (bus_addr[ADDR_W-1:2] == A_RES[ADDR_W-1:2]);
  assign sel_any  = sel_ctrl | sel_phy | sel_cfg | sel_mask | sel_src | sel_res;

  assign clr_vec = (bus_wr && sel_src) ? (bus_wdata & SRC_KEEP) : '0;

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) begin
      rd_mux = ctrl_q;
      rd_mux[B_UPD]  = upd_pulse;
      rd_mux[B_SRST] = srst_pulse;
    end
    if (sel_phy)  rd_mux = phy_q;
    if (sel_cfg)  rd_mux = cfg_q;
    if (sel_mask) rd_mux = mask_q;
    if (sel_src)  rd_mux = src_q;
    if (sel_res)  rd_mux = res_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      phy_q      <= '0;
      cfg_q      <= '0;
      res_q      <= '0;
      mask_q     <= '0;
      upd_pulse  <= 1'b0;
      srst_pulse <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      upd_pulse  <= bus_wr && sel_ctrl && bus_wdata[B_UPD];
      srst_pulse <= bus_wr && sel_ctrl && bus_wdata[B_SRST];
      if (bus_wr) begin
        if (sel_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
        if (sel_phy)  phy_q  <= bus_wdata & PHY_KEEP;
        if (sel_cfg)  cfg_q  <= bus_wdata & CFG_KEEP;
        if (sel_mask) mask_q <= bus_wdata & MASK_KEEP;
        if (sel_res)  res_q  <= bus_wdata;
      end
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assert_upd_selfclear_R4: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |=> (!upd_pulse || $past(bus_wr && sel_ctrl && bus_wdata[B_UPD])));

  assert_srst_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    srst_pulse |=> (!srst_pulse || $past(bus_wr && sel_ctrl && bus_wdata[B_SRST])));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !sel_any) |=> (bus_rdata == '0));

  assert_unmapped_write_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !sel_any) |=> ($stable(cfg_q) && $stable(phy_q) && $stable(res_q) && $stable(mask_q)));
endmodule

// File: rtl/cam_rx_evt_status.sv
module cam_rx_evt_status
  import cam_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             srst,
  input  logic [REG_W-1:0] ev_vec,
  input  logic [REG_W-1:0] clr_vec,
  input  logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] src_q,
  output logic             irq
);
  logic [REG_W-1:0] mask_eff;
  logic [REG_W-1:0] ev_live;

  assign ev_live = ev_vec & SRC_KEEP;

  for (genvar b = 0; b < REG_W; b++) begin : g_mask
    if (b >= B_SOT0 && b < B_SOT0 + SOT_W) begin : g_sot
      assign mask_eff[b] = mask_q[B_SOT0];
    end else begin : g_plain
      assign mask_eff[b] = mask_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      src_q <= '0;
      irq   <= 1'b0;
    end else begin
      src_q <= (ev_live | (src_q & ~clr_vec)) & SRC_KEEP;
      irq   <= |(src_q & mask_eff);
    end
  end

  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!srst && clr_vec == '0) |=> ((src_q & $past(src_q)) == $past(src_q)));

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (!srst && ev_live != '0) |=> ((src_q & $past(ev_live)) == $past(ev_live)));

  assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq);

  assert_srst_clears_R6: assert property (@(posedge clk) disable iff (rst)
    srst |=> (src_q == '0));
endmodule

// File: rtl/cam_rx_shadow.sv
module cam_rx_shadow
  import cam_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 srst,
  input  logic                 upd,
  input  logic                 in_swap,
  input  logic                 in_align32,
  input  logic                 in_wclk_ext,
  input  logic [7:0]           in_cfg,
  input  logic [4:0]           in_settle,
  input  logic [LANE_EN_W-1:0] in_lane_en,
  input  logic [REG_W-1:0]     in_res,
  output shadow_t              sh_q
);
  logic [LANE_EN_W-1:0] lane_mask;
  shadow_t              nxt;

  for (genvar i = 0; i < LANE_EN_W; i++) begin : g_lane
    assign lane_mask[i] = (i <= (int'(in_cfg[1:0]) + 1));
  end

  always_comb begin
    nxt.swap     = in_swap;
    nxt.align32  = in_align32;
    nxt.wclk_ext = in_wclk_ext;
    nxt.lane_cnt = in_cfg[1:0];
    nxt.dtype    = in_cfg[7:2];
    nxt.width    = in_res[31:16];
    nxt.height   = in_res[15:0];
    nxt.settle   = in_settle;
    nxt.lane_en  = in_lane_en & lane_mask;
  end

  always_ff @(posedge clk) begin
    if (rst || srst) sh_q <= '0;
    else if (upd)    sh_q <= nxt;
  end

  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!upd && !srst) |=> $stable(sh_q));

  assert_shadow_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    srst |=> (sh_q == '0));

  assert_lane_subset_R5: assert property (@(posedge clk) disable iff (rst)
    (upd && !srst) |=> ((sh_q.lane_en & ~$past(in_lane_en)) == '0));
endmodule

// File: rtl/cam_rx_csr.sv
module cam_rx_csr
  import cam_rx_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  input  logic [ERR_W-1:0]     ev_err,
  input  logic [SOT_W-1:0]     ev_sot,
  input  logic [NI_W-1:0]      ev_nonimg,
  output logic                 irq,
  output logic                 dp_enable,
  output logic                 dp_soft_rst,
  output logic                 dp_swap,
  output logic                 dp_wclk_ext,
  output logic                 dp_align32,
  output logic [1:0]           dp_lane_cnt,
  output logic [5:0]           dp_dtype,
  output logic [15:0]          dp_width,
  output logic [15:0]          dp_height,
  output logic [4:0]           dp_settle,
  output logic [LANE_EN_W-1:0] dp_lane_en
);
  localparam int unsigned GAP_HI = 28 - (B_SOT0 + SOT_W);
  localparam int unsigned GAP_LO = B_SOT0 - ERR_W;

  logic [REG_W-1:0] ctrl_q, phy_q, cfg_q, res_q, mask_q, src_q, clr_vec, ev_vec;
  logic             upd_pulse, srst_pulse;
  shadow_t          sh_q;

  assign ev_vec = {ev_nonimg, {GAP_HI{1'b0}}, ev_sot, {GAP_LO{1'b0}}, ev_err};

  cam_rx_regbank #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .src_q(src_q),
    .ctrl_q(ctrl_q), .phy_q(phy_q), .cfg_q(cfg_q), .res_q(res_q),
    .mask_q(mask_q), .upd_pulse(upd_pulse), .srst_pulse(srst_pulse),
    .clr_vec(clr_vec), .bus_rdata(bus_rdata)
  );

  cam_rx_evt_status u_evt (
    .clk(clk), .rst(rst), .srst(srst_pulse), .ev_vec(ev_vec),
    .clr_vec(clr_vec), .mask_q(mask_q), .src_q(src_q), .irq(irq)
  );

  cam_rx_shadow u_shadow (
    .clk(clk), .rst(rst), .srst(srst_pulse), .upd(upd_pulse),
    .in_swap(ctrl_q[B_SWAP]), .in_align32(ctrl_q[B_ALIGN]),
    .in_wclk_ext(ctrl_q[B_WCLK]), .in_cfg(cfg_q[7:0]),
    .in_settle(phy_q[31:27]), .in_lane_en(phy_q[LANE_EN_W-1:0]),
    .in_res(res_q), .sh_q(sh_q)
  );

  assign dp_enable   = ctrl_q[B_EN];
  assign dp_soft_rst = srst_pulse;
  assign dp_swap     = sh_q.swap;
  assign dp_wclk_ext = sh_q.wclk_ext;
  assign dp_align32  = sh_q.align32;
  assign dp_lane_cnt = sh_q.lane_cnt;
  assign dp_dtype    = sh_q.dtype;
  assign dp_width    = sh_q.width;
  assign dp_height   = sh_q.height;
  assign dp_settle   = sh_q.settle;
  assign dp_lane_en  = sh_q.lane_en;

  assert_enable_live_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFF_CTRL)) |=> (dp_enable == $past(bus_wdata[B_EN])));
endmodule

// File: tb/test_cam_rx_csr.sv
module test_cam_rx_csr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  ev_err = '0;
  logic [3:0]  ev_sot = '0;
  logic [3:0]  ev_nonimg = '0;
  logic        irq, dp_enable, dp_soft_rst, dp_swap, dp_wclk_ext, dp_align32;
  logic [1:0]  dp_lane_cnt;
  logic [5:0]  dp_dtype;
  logic [15:0] dp_width, dp_height;
  logic [4:0]  dp_settle, dp_lane_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #4 clk = ~clk;

  cam_rx_csr i_cam_rx_csr (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_err(ev_err), .ev_sot(ev_sot),
    .ev_nonimg(ev_nonimg), .irq(irq), .dp_enable(dp_enable), .dp_soft_rst(dp_soft_rst),
    .dp_swap(dp_swap), .dp_wclk_ext(dp_wclk_ext), .dp_align32(dp_align32),
    .dp_lane_cnt(dp_lane_cnt), .dp_dtype(dp_dtype), .dp_width(dp_width),
    .dp_height(dp_height), .dp_settle(dp_settle), .dp_lane_en(dp_lane_en)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(logic [5:0] e, logic [3:0] s, logic [3:0] n);
    @(negedge clk);
    ev_err = e; ev_sot = s; ev_nonimg = n;
    @(negedge clk);
    ev_err = '0; ev_sot = '0; ev_nonimg = '0;
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL scoreboard: read with no expectation, got %08h expected none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    tick(4);
    rst = 1'b0;
    // R1: reset state
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 dp_enable", {31'b0, dp_enable}, 0);
    check("R1 dp_dtype", {26'b0, dp_dtype}, 0);
    check("R1 dp_lane_en", {27'b0, dp_lane_en}, 0);
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(8'h04, 32'h0, "R1 phy");
    rd(8'h08, 32'h0, "R1 cfg");
    rd(8'h10, 32'h0, "R1 mask");
    rd(8'h14, 32'h0, "R1 src");
    rd(8'h2C, 32'h0, "R1 res");

    // R2: implemented bits only
    wr(8'h04, 32'hFFFF_FFFF);  rd(8'h04, 32'hF800_001F, "R2 phy");
    wr(8'h08, 32'hFFFF_FFFF);  rd(8'h08, 32'h0000_00FF, "R2 cfg");
    wr(8'h10, 32'hFFFF_FFFF);  rd(8'h10, 32'hF000_103F, "R2 mask");
    wr(8'h10, 32'h0);
    wr(8'h2C, 32'h1234_5678);  rd(8'h2C, 32'h1234_5678, "R2 res");
    wr(8'h00, 32'h8010_0101);  rd(8'h00, 32'h8010_0101, "R2 ctrl");
    // R12: enable is live
    check("R12 dp_enable", {31'b0, dp_enable}, 1);
    check("R3 no update yet", {26'b0, dp_dtype}, 0);

    // R3/R5: stage, then update
    wr(8'h08, 32'h0000_00AD);   // dtype 0x2B, lanes field 1
    wr(8'h04, 32'h2800_001F);   // settle 5, all lane enables
    wr(8'h2C, 32'h0280_01E0);
    tick(2);
    check("R3 staged hold", {26'b0, dp_dtype}, 0);
    wr(8'h00, 32'h8011_0101);
    tick(1);
    check("R3 dtype", {26'b0, dp_dtype}, 32'h2B);
    check("R3 lane_cnt", {30'b0, dp_lane_cnt}, 1);
    check("R3 width", {16'b0, dp_width}, 32'h280);
    check("R3 height", {16'b0, dp_height}, 32'h1E0);
    check("R3 settle", {27'b0, dp_settle}, 5);
    check("R3 flags", {29'b0, dp_swap, dp_align32, dp_wclk_ext}, 3'b111);
    check("R5 lane_en two lanes", {27'b0, dp_lane_en}, 32'h07);
    rd(8'h00, 32'h8010_0101, "R4 update self-clear");

    wr(8'h08, 32'h0000_00C3);   // dtype 0x30, lanes field 3
    tick(2);
    check("R3 hold after cfg write", {26'b0, dp_dtype}, 32'h2B);
    wr(8'h00, 32'h8011_0101);
    tick(1);
    check("R3 dtype user1", {26'b0, dp_dtype}, 32'h30);
    check("R5 lane_en four lanes", {27'b0, dp_lane_en}, 32'h1F);

    // R7/R10: events with mask off
    pulse(6'b000101, 4'b0100, 4'b1001);
    tick(2);
    rd(8'h14, 32'h9000_4005, "R7 sticky sources");
    check("R10 masked irq", {31'b0, irq}, 0);
    wr(8'h10, 32'h0000_1000);
    tick(1);
    check("R10 sot group irq", {31'b0, irq}, 1);

    // R8: write-one clear
    wr(8'h14, 32'h0000_4000);
    tick(1);
    rd(8'h14, 32'h9000_0005, "R8 w1c");
    check("R10 irq drops", {31'b0, irq}, 0);

    // R9: event wins over clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h1; ev_err = 6'b000001;
    @(negedge clk);
    bus_wr = 1'b0; ev_err = '0;
    rd(8'h14, 32'h9000_0005, "R9 event wins");
    wr(8'h14, 32'h9000_0004);
    rd(8'h14, 32'h0000_0001, "R8 zeros keep");

    // R11: unmapped
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h09, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0, "R11 unmapped read");
    rd(8'h18, 32'h0, "R11 unmapped read2");
    rd(8'h08, 32'h0000_00C3, "R11 cfg untouched");
    rd(8'h10, 32'h0000_1000, "R11 mask untouched");

    // R6: soft reset
    wr(8'h00, 32'h8010_0111);
    check("R6 pulse high", {31'b0, dp_soft_rst}, 1);
    tick(1);
    check("R6 pulse low", {31'b0, dp_soft_rst}, 0);
    check("R6 shadow dtype cleared", {26'b0, dp_dtype}, 0);
    check("R6 shadow lanes cleared", {27'b0, dp_lane_en}, 0);
    check("R6 enable kept", {31'b0, dp_enable}, 1);
    rd(8'h14, 32'h0, "R6 sources cleared");
    rd(8'h08, 32'h0000_00C3, "R6 cfg kept");
    rd(8'h00, 32'h8010_0101, "R6 ctrl readback");

    tick(3);
    check("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule